// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block is a single eight-line interrupt controller slice. It keeps three bit vectors: pending requests, lines in service and masked lines. A fourth vector picks, line by line, whether a request is captured on a rising edge or follows the line level. In every cycle the block finds the best unmasked pending request and the best in-service line. It raises its interrupt output only when the request outranks everything already in service.

Priority rotates. A base offset names the line that currently has top priority, and the lines after it rank in ascending order, wrapping modulo eight. The surrounding logic acknowledges the winner with a strobe. It retires in-service lines with non-specific or specific end-of-interrupt strobes, and either kind can also rotate the base. It can place the base directly by naming the line that should rank lowest. Three mode inputs select automatic end-of-interrupt, rotation on automatic end-of-interrupt and special fully nested behaviour. Bus decoding, initialisation sequencing and cascading between slices are handled by other blocks.

Top module: `rpi_core`

## Requirements
- R1: After reset the request, in-service, mask and trigger vectors, the base offset, `irq_out` and `irq_line` are all zero.
- R2: A line whose trigger bit is 1 (level) has its request bit equal to the line value sampled at the previous clock edge. An acknowledge does not clear it.
- R3: A line whose trigger bit is 0 (edge) sets its request bit only when it is high at a clock edge after being low at the previous edge. A falling line leaves the request bit set. An acknowledge clears it, and a line held high does not set it again.
- R4: A trigger write stores `trig_wdata & TRIG_WRITE_MASK` (default 8'hF8). Bits outside the mask stay 0, so those lines are always edge-triggered.
- R5: The best line is found by scanning lines base, base+1, … modulo 8. The first set bit wins, and `irq_line` reports its number.
- R6: `irq_out` is 1 only when an unmasked request exists and its rotated rank is strictly lower than the rank of the best in-service line. Masked requests are never selected.
- R7: When `IS_MASTER` is nonzero and `sfn_en` is 1, in-service bit `CASCADE_LINE` (default 2) is ignored in the in-service rank, so a new request on that line can be raised again.
- R8: An acknowledge while a request is resolved sets that line's in-service bit and clears an edge-mode request bit. An acknowledge with nothing resolved changes no state.
- R9: With `auto_eoi_en` = 1, an acknowledge leaves the in-service bit clear. If `rot_auto_eoi_en` is also 1, the base becomes the acknowledged line + 1 modulo 8.
- R10: A non-specific EOI clears the best-ranked in-service bit. With `eoi_rot` = 1 it also sets the base to that line + 1 modulo 8.
- R11: A specific EOI clears in-service bit `eoi_sp_line`. With `eoi_rot` = 1 it also sets the base to that line + 1 modulo 8.
- R12: A base command sets the base to `setbase_line` + 1 modulo 8, so the named line ranks last.
- R13: `irq_out` and `irq_line` are registered. They reflect the state that held during the previous cycle, one clock after the state changes.
- R14: When several command strobes are high in the same cycle, only one of them acts. The order is acknowledge, then non-specific EOI, then specific EOI, then base command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lines_in | input | 8 | Interrupt request lines |
| imr_we | input | 1 | Mask write strobe |
| imr_wdata | input | 8 | New mask vector, 1 = masked |
| trig_we | input | 1 | Trigger-mode write strobe |
| trig_wdata | input | 8 | New trigger vector, 1 = level, 0 = edge |
| ack | input | 1 | Acknowledge of the resolved line |
| eoi_ns | input | 1 | Non-specific end-of-interrupt |
| eoi_sp | input | 1 | Specific end-of-interrupt |
| eoi_sp_line | input | 3 | Line retired by a specific EOI |
| eoi_rot | input | 1 | Rotate the base along with an EOI |
| setbase_en | input | 1 | Base command strobe |
| setbase_line | input | 3 | Line that should rank lowest |
| auto_eoi_en | input | 1 | Automatic end-of-interrupt mode |
| rot_auto_eoi_en | input | 1 | Rotate on automatic end-of-interrupt |
| sfn_en | input | 1 | Special fully nested mode |
| irq_out | output | 1 | Registered interrupt request |
| irq_line | output | 3 | Registered winning line number |
| irr_out | output | 8 | Request vector |
| isr_out | output | 8 | In-service vector |
| imr_out | output | 8 | Mask vector |
| trig_out | output | 8 | Trigger vector |
| base_out | output | 3 | Current base offset |

## Verification
The edge-capture property assumes that the request lines are low while reset is held. Reset clears the stored previous line level, so a line already high at release counts as a rising edge, and the bench zeroes every line before each reset pulse. The EOI bookkeeping property assumes that a non-specific EOI it judges is not paired with an acknowledge. The bench pairs the two only in the one directed test of command precedence, where the property's guard excludes it. Every other stimulus pulses one command strobe at a time, for a single cycle, between falling clock edges.

// File: rtl/rpi_pkg.sv
`timescale 1ns/1ps
package rpi_pkg;

    typedef enum logic [2:0] {
        CMD_IDLE   = 3'd0,
        CMD_ACK    = 3'd1,
        CMD_EOI_NS = 3'd2,
        CMD_EOI_SP = 3'd3,
        CMD_BASE   = 3'd4
    } rpi_cmd_e;

    // Fixed precedence among command strobes that arrive together.
    function automatic rpi_cmd_e pick_cmd(input logic a, input logic ns,
                                          input logic sp, input logic bs);
        if (a)       return CMD_ACK;
        else if (ns) return CMD_EOI_NS;
        else if (sp) return CMD_EOI_SP;
        else if (bs) return CMD_BASE;
        else         return CMD_IDLE;
    endfunction

endpackage

// File: rtl/rpi_scan.sv
`timescale 1ns/1ps
// Rotated priority scan: returns the rank of the first set bit counting
// upward from base, or N_LINES when the vector is empty.
module rpi_scan #(
    parameter int N_LINES = 8,
    localparam int IW = $clog2(N_LINES)
) (
    input  logic [N_LINES-1:0] vec,
    input  logic [IW-1:0]      base,
    output logic [IW:0]        rank
);
    logic [IW-1:0] idx;

    always_comb begin
        rank = (IW+1)'(N_LINES);
        idx  = '0;
        for (int k = N_LINES - 1; k >= 0; k--) begin
            idx = base + IW'(k);
            if (vec[idx]) begin
                rank = (IW+1)'(k);
            end
        end
    end
endmodule

// File: rtl/rpi_req_latch.sv
`timescale 1ns/1ps
// Per-line request capture: level lines follow the input, edge lines
// latch a rising transition and are cleared only by acknowledge.
module rpi_req_latch #(
    parameter int N_LINES = 8
) (
    input  logic [N_LINES-1:0] lines,
    input  logic [N_LINES-1:0] last_q,
    input  logic [N_LINES-1:0] trig_q,
    input  logic [N_LINES-1:0] irr_q,
    input  logic [N_LINES-1:0] clr,
    output logic [N_LINES-1:0] irr_d,
    output logic [N_LINES-1:0] last_d
);
    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        always_comb begin
            if (trig_q[i]) begin
                irr_d[i] = lines[i];
            end else begin
                irr_d[i] = (irr_q[i] & ~clr[i]) | (lines[i] & ~last_q[i]);
            end
        end
        assign last_d[i] = lines[i];
    end
endmodule

// File: rtl/rpi_core.sv
`timescale 1ns/1ps
module rpi_core #(
    parameter int             N_LINES         = 8,
    parameter logic [N_LINES-1:0] TRIG_WRITE_MASK = 8'hF8,
    parameter int             IS_MASTER       = 1,
    parameter int             CASCADE_LINE    = 2,
    localparam int            IW              = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] lines_in,
    input  logic               imr_we,
    input  logic [N_LINES-1:0] imr_wdata,
    input  logic               trig_we,
    input  logic [N_LINES-1:0] trig_wdata,
    input  logic               ack,
    input  logic               eoi_ns,
    input  logic               eoi_sp,
    input  logic [IW-1:0]      eoi_sp_line,
    input  logic               eoi_rot,
    input  logic               setbase_en,
    input  logic [IW-1:0]      setbase_line,
    input  logic               auto_eoi_en,
    input  logic               rot_auto_eoi_en,
    input  logic               sfn_en,
    output logic               irq_out,
    output logic [IW-1:0]      irq_line,
    output logic [N_LINES-1:0] irr_out,
    output logic [N_LINES-1:0] isr_out,
    output logic [N_LINES-1:0] imr_out,
    output logic [N_LINES-1:0] trig_out,
    output logic [IW-1:0]      base_out
);
    import rpi_pkg::*;

    typedef struct packed {
        logic [N_LINES-1:0] irr;
        logic [N_LINES-1:0] isr;
        logic [N_LINES-1:0] imr;
        logic [N_LINES-1:0] trig;
        logic [N_LINES-1:0] last;
        logic [IW-1:0]      base;
        logic               irq;
        logic [IW-1:0]      line;
    } st_t;

    st_t st_q, st_d;

    logic [N_LINES-1:0] req_vec_d, isr_eff_d, clr_d;
    logic [N_LINES-1:0] irr_lat_d, last_lat_d;
    logic [N_LINES-1:0] win_bit_d, hi_isr_bit_d, sp_bit_d;
    logic [IW:0]        req_rank_d, cur_rank_d, hi_rank_d;
    logic [IW-1:0]      win_line_d, hi_line_d;
    logic               pend_d, hi_found_d;
    rpi_cmd_e           cmd_d;

    // Resolution inputs
    always_comb begin
        req_vec_d = st_q.irr & ~st_q.imr;
        isr_eff_d = st_q.isr;
        if ((IS_MASTER != 0) && sfn_en) begin
            isr_eff_d[CASCADE_LINE] = 1'b0;
        end
    end

    rpi_scan #(.N_LINES(N_LINES)) u_req_scan (
        .vec  (req_vec_d),
        .base (st_q.base),
        .rank (req_rank_d)
    );

    rpi_scan #(.N_LINES(N_LINES)) u_cur_scan (
        .vec  (isr_eff_d),
        .base (st_q.base),
        .rank (cur_rank_d)
    );

    rpi_scan #(.N_LINES(N_LINES)) u_eoi_scan (
        .vec  (st_q.isr),
        .base (st_q.base),
        .rank (hi_rank_d)
    );

    always_comb begin
        pend_d       = ~req_rank_d[IW] && (req_rank_d < cur_rank_d);
        win_line_d   = st_q.base + req_rank_d[IW-1:0];
        hi_found_d   = ~hi_rank_d[IW];
        hi_line_d    = st_q.base + hi_rank_d[IW-1:0];
        win_bit_d    = N_LINES'(1) << win_line_d;
        hi_isr_bit_d = N_LINES'(1) << hi_line_d;
        sp_bit_d     = N_LINES'(1) << eoi_sp_line;
        cmd_d        = pick_cmd(ack, eoi_ns, eoi_sp, setbase_en);
    end

    // Acknowledge clears the request only on edge-mode lines.
    always_comb begin
        clr_d = '0;
        if (cmd_d == CMD_ACK && pend_d) begin
            clr_d = win_bit_d & ~st_q.trig;
        end
    end

    rpi_req_latch #(.N_LINES(N_LINES)) u_latch (
        .lines  (lines_in),
        .last_q (st_q.last),
        .trig_q (st_q.trig),
        .irr_q  (st_q.irr),
        .clr    (clr_d),
        .irr_d  (irr_lat_d),
        .last_d (last_lat_d)
    );

    // Next-state computation
    always_comb begin
        st_d      = st_q;
        st_d.irr  = irr_lat_d;
        st_d.last = last_lat_d;

        unique case (cmd_d)
            CMD_ACK: begin
                if (pend_d) begin
                    if (!auto_eoi_en) begin
                        st_d.isr = st_q.isr | win_bit_d;
                    end else if (rot_auto_eoi_en) begin
                        st_d.base = win_line_d + IW'(1);
                    end
                end
            end
            CMD_EOI_NS: begin
                if (hi_found_d) begin
                    st_d.isr = st_q.isr & ~hi_isr_bit_d;
                    if (eoi_rot) begin
                        st_d.base = hi_line_d + IW'(1);
                    end
                end
            end
            CMD_EOI_SP: begin
                st_d.isr = st_q.isr & ~sp_bit_d;
                if (eoi_rot) begin
                    st_d.base = eoi_sp_line + IW'(1);
                end
            end
            CMD_BASE: begin
                st_d.base = setbase_line + IW'(1);
            end
            default: begin
            end
        endcase

        if (imr_we) begin
            st_d.imr = imr_wdata;
        end
        if (trig_we) begin
            st_d.trig = trig_wdata & TRIG_WRITE_MASK;
        end

        st_d.irq  = pend_d;
        st_d.line = pend_d ? win_line_d : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_out  = st_q.irq;
    assign irq_line = st_q.line;
    assign irr_out  = st_q.irr;
    assign isr_out  = st_q.isr;
    assign imr_out  = st_q.imr;
    assign trig_out = st_q.trig;
    assign base_out = st_q.base;

endmodule

// File: rtl/rpi_core_chk.sv
`timescale 1ns/1ps
module rpi_core_chk #(
    parameter int                 N_LINES   = 8,
    parameter logic [N_LINES-1:0] TRIG_MASK = 8'hF8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_LINES-1:0] lines_in,
    input logic               trig_we,
    input logic [N_LINES-1:0] trig_wdata,
    input logic               ack,
    input logic               eoi_ns,
    input logic               auto_eoi_en,
    input logic               irq_out,
    input logic [N_LINES-1:0] irr_out,
    input logic [N_LINES-1:0] isr_out,
    input logic [N_LINES-1:0] imr_out,
    input logic [N_LINES-1:0] trig_out
);
    // R6 / R13: a raised output needs an unmasked request one cycle earlier
    assert_irq_has_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ($past(irr_out & ~imr_out) != '0));

    // R4: trigger writes are filtered by the fixed mask
    assert_trig_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(trig_we) |-> (trig_out == ($past(trig_wdata) & TRIG_MASK)));

    // R2: level-mode request bits mirror the previous line sample
    assert_level_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((irr_out ^ $past(lines_in)) & $past(trig_out)) == '0);

    // R3: a newly set edge-mode bit needs a low-to-high transition
    assert_edge_needs_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irr_out & ~$past(irr_out) & ~$past(trig_out)
         & ~($past(lines_in) & ~$past(lines_in, 2))) == '0);

    // R8: in-service bits appear only on acknowledge, one at a time
    assert_isr_set_by_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(isr_out & ~$past(isr_out)) <= ($past(ack) ? 1 : 0));

    // R9: automatic end-of-interrupt never leaves a new in-service bit
    assert_auto_eoi_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(auto_eoi_en) |-> ((isr_out & ~$past(isr_out)) == '0));

    // R10: a lone non-specific EOI retires exactly one in-service bit
    assert_eoi_ns_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(eoi_ns && !ack && (isr_out != '0))
        |-> ($countones(isr_out) == $countones($past(isr_out)) - 1));
endmodule

bind rpi_core rpi_core_chk #(.N_LINES(N_LINES), .TRIG_MASK(TRIG_WRITE_MASK)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lines_in    (lines_in),
    .trig_we     (trig_we),
    .trig_wdata  (trig_wdata),
    .ack         (ack),
    .eoi_ns      (eoi_ns),
    .auto_eoi_en (auto_eoi_en),
    .irq_out     (irq_out),
    .irr_out     (irr_out),
    .isr_out     (isr_out),
    .imr_out     (imr_out),
    .trig_out    (trig_out)
);

// File: tb/sim_rpi_core.sv
`timescale 1ns/1ps
module sim_rpi_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] lines_in = '0, imr_wdata = '0, trig_wdata = '0;
    logic       imr_we = 0, trig_we = 0, ack = 0, eoi_ns = 0, eoi_sp = 0, eoi_rot = 0;
    logic [2:0] eoi_sp_line = '0, setbase_line = '0;
    logic       setbase_en = 0, auto_eoi_en = 0, rot_auto_eoi_en = 0, sfn_en = 0;
    logic       irq_out;
    logic [2:0] irq_line, base_out;
    logic [7:0] irr_out, isr_out, imr_out, trig_out;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rpi_core u0 (
        .clk(clk), .rst_n(rst_n), .lines_in(lines_in),
        .imr_we(imr_we), .imr_wdata(imr_wdata),
        .trig_we(trig_we), .trig_wdata(trig_wdata),
        .ack(ack), .eoi_ns(eoi_ns), .eoi_sp(eoi_sp), .eoi_sp_line(eoi_sp_line),
        .eoi_rot(eoi_rot), .setbase_en(setbase_en), .setbase_line(setbase_line),
        .auto_eoi_en(auto_eoi_en), .rot_auto_eoi_en(rot_auto_eoi_en), .sfn_en(sfn_en),
        .irq_out(irq_out), .irq_line(irq_line), .irr_out(irr_out), .isr_out(isr_out),
        .imr_out(imr_out), .trig_out(trig_out), .base_out(base_out)
    );

    // Fields: [22:20] expected line, [19] expected irq, [18:16] lowest-rank line,
    // [15:8] mask, [7:0] lines
    localparam logic [31:0] TBL [10] = '{
        {9'd0, 3'd0, 1'b1, 3'd7, 8'h00, 8'h01},
        {9'd0, 3'd0, 1'b1, 3'd7, 8'h00, 8'h81},
        {9'd0, 3'd7, 1'b1, 3'd0, 8'h00, 8'h81},
        {9'd0, 3'd5, 1'b1, 3'd3, 8'h00, 8'h24},
        {9'd0, 3'd2, 1'b1, 3'd5, 8'h00, 8'h24},
        {9'd0, 3'd2, 1'b1, 3'd3, 8'h20, 8'h24},
        {9'd0, 3'd0, 1'b0, 3'd7, 8'hFF, 8'hFF},
        {9'd0, 3'd0, 1'b0, 3'd7, 8'h00, 8'h00},
        {9'd0, 3'd7, 1'b1, 3'd7, 8'h7F, 8'h80},
        {9'd0, 3'd3, 1'b1, 3'd2, 8'h00, 8'h18}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic do_reset();
        lines_in = '0; imr_we = 0; trig_we = 0; ack = 0; eoi_ns = 0; eoi_sp = 0;
        eoi_rot = 0; setbase_en = 0; auto_eoi_en = 0; rot_auto_eoi_en = 0; sfn_en = 0;
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic pulse_ack();
        ack = 1; cyc(); ack = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL R13 watchdog: actual=running expected=finished");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        check("R1 irr", irr_out, 0);
        check("R1 isr", isr_out, 0);
        check("R1 imr", imr_out, 0);
        check("R1 trig", trig_out, 0);
        check("R1 base", base_out, 0);
        check("R1 irq", irq_out, 0);

        // R5/R6/R12: resolution table
        for (int e = 0; e < 10; e++) begin
            do_reset();
            setbase_line = TBL[e][18:16]; setbase_en = 1;
            imr_wdata = TBL[e][15:8]; imr_we = 1;
            cyc();
            setbase_en = 0; imr_we = 0;
            lines_in = TBL[e][7:0];
            cyc(); cyc();
            check("R12 base", base_out, 32'(3'(TBL[e][18:16] + 3'd1)));
            check("R6 irq", irq_out, 32'(TBL[e][19]));
            if (TBL[e][19]) check("R5 line", irq_line, 32'(TBL[e][22:20]));
        end

        // R13 / R3: timing and edge capture
        do_reset();
        lines_in = 8'h01; cyc();
        check("R3 edge set", irr_out, 8'h01);
        check("R13 irq lags", irq_out, 0);
        cyc();
        check("R13 irq", irq_out, 1);
        pulse_ack();
        check("R8 isr", isr_out, 8'h01);
        check("R3 ack clears", irr_out, 8'h00);
        check("R13 irq still up", irq_out, 1);
        cyc();
        check("R13 irq drops", irq_out, 0);
        cyc();
        check("R3 held high no reset", irr_out, 8'h00);
        eoi_ns = 1; cyc(); eoi_ns = 0;
        check("R10 clear", isr_out, 8'h00);
        lines_in = 0; cyc();
        lines_in = 8'h01; cyc();
        check("R3 re-rise", irr_out, 8'h01);
        lines_in = 0; cyc();
        check("R3 fall keeps", irr_out, 8'h01);

        // R4 / R2: masked trigger write, level behaviour
        do_reset();
        trig_wdata = 8'hFF; trig_we = 1; cyc(); trig_we = 0;
        check("R4 trig", trig_out, 8'hF8);
        lines_in = 8'h08; cyc();
        check("R2 level set", irr_out, 8'h08);
        pulse_ack();
        check("R8 isr level", isr_out, 8'h08);
        check("R2 ack keeps", irr_out, 8'h08);
        lines_in = 0; cyc();
        check("R2 level clear", irr_out, 8'h00);

        // R8 / R6 / R10 / R11 / R12
        do_reset();
        pulse_ack();
        check("R8 idle ack", isr_out, 8'h00);
        lines_in = 8'h20; cyc();
        pulse_ack();
        check("R8 isr5", isr_out, 8'h20);
        lines_in = 8'h60; cyc(); cyc();
        check("R6 blocked", irq_out, 0);
        lines_in = 8'h62; cyc(); cyc();
        check("R6 higher", irq_out, 1);
        check("R5 line1", irq_line, 1);
        pulse_ack();
        check("R8 isr15", isr_out, 8'h22);
        eoi_ns = 1; eoi_rot = 1; cyc(); eoi_ns = 0; eoi_rot = 0;
        check("R10 rot isr", isr_out, 8'h20);
        check("R10 rot base", base_out, 2);
        cyc();
        check("R6 rotated block", irq_out, 0);
        eoi_ns = 1; cyc(); eoi_ns = 0;
        check("R10 plain isr", isr_out, 8'h00);
        check("R10 plain base", base_out, 2);
        cyc();
        check("R6 line6 up", irq_out, 1);
        check("R5 line6", irq_line, 6);
        pulse_ack();
        check("R8 isr6", isr_out, 8'h40);
        eoi_sp = 1; eoi_sp_line = 3'd6; eoi_rot = 1; cyc(); eoi_sp = 0; eoi_rot = 0;
        check("R11 isr", isr_out, 8'h00);
        check("R11 base", base_out, 7);
        setbase_line = 3'd3; setbase_en = 1; cyc(); setbase_en = 0;
        check("R12 base", base_out, 4);

        // R9: automatic end-of-interrupt
        do_reset();
        auto_eoi_en = 1; rot_auto_eoi_en = 1;
        lines_in = 8'h10; cyc();
        pulse_ack();
        check("R9 isr", isr_out, 8'h00);
        check("R9 irr", irr_out, 8'h00);
        check("R9 base", base_out, 5);
        rot_auto_eoi_en = 0;
        lines_in = 8'h11; cyc();
        pulse_ack();
        check("R9 no rot isr", isr_out, 8'h00);
        check("R9 no rot base", base_out, 5);

        // R7: special fully nested
        do_reset();
        lines_in = 8'h04; cyc();
        pulse_ack();
        check("R7 isr2", isr_out, 8'h04);
        lines_in = 0; cyc();
        lines_in = 8'h04; cyc(); cyc();
        check("R7 off blocked", irq_out, 0);
        sfn_en = 1; cyc(); cyc();
        check("R7 on raised", irq_out, 1);
        check("R7 line", irq_line, 2);

        // R14: command precedence
        do_reset();
        lines_in = 8'h08; cyc();
        pulse_ack();
        lines_in = 8'h0A; cyc();
        ack = 1; eoi_ns = 1; cyc(); ack = 0; eoi_ns = 0;
        check("R14 ack wins", isr_out, 8'h0A);
        eoi_sp = 1; eoi_sp_line = 3'd3; setbase_en = 1; setbase_line = 3'd0; cyc();
        eoi_sp = 0; setbase_en = 0;
        check("R14 eoi wins isr", isr_out, 8'h02);
        check("R14 eoi wins base", base_out, 0);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule